// File: doc/BRIEF.md
# Byte-Wide SPI Master

This block is an SPI master that moves one byte per transfer and keeps no queue. A host drives it through a small 8-bit register bus with a 3-bit byte address. The host writes a byte to the transmit register and then writes the control register with its start bit set. The controller shifts the byte out on `mosi` and samples `miso` at the same time. When the byte is done, it latches the received byte, sets a receive-ready flag and raises `irq`. Reading the received byte clears the flag and drops `irq`. The host must service every byte this way.

The mode register sets the serial timing:
- SCK idle level.
- Which SCK edge samples data. This bit is the inverse of the usual clock-phase bit.
- Shift order, MSB first or LSB first.
- An internal loopback from the outgoing bit to the receiver.
- A port enable.

An 8-bit divisor register sets the SCK rate. SCK runs at the system clock divided by 4·(divisor+1).

Top module: `spi_byte_master`

## Requirements
- R1: The register map is at these byte addresses. Mode is at 0, received data at 1, transmit data at 2, control at 3, status at 4 and divisor at 6. Address 5 reads zero. Mode, transmit and divisor read back what was written, except that mode bits 7..5 read 0. All registers reset to 0. Writes to addresses 1, 4 and 5 have no effect.
- R2: With the port enabled (mode bit 3) and the port idle, a write to address 3 with bit 0 set starts a transfer of the transmit byte. The transfer shifts exactly 8 bits, and the slave sees the transmit byte.
- R3: Mode bit 1 sets the SCK idle level (1 means idle high). SCK sits at that level before and after every transfer, and it gives 8 pulses during a transfer.
- R4: The transmit bit changes on one SCK edge and the receive bit is sampled on the other. With mode bit 4 set, data is sampled on the leading edge and changes on the trailing edge, and the first bit is on `mosi` before the first edge. With mode bit 4 clear, data changes on the leading edge and is sampled on the trailing edge.
- R5: With mode bit 2 clear, both directions go MSB first. With mode bit 2 set, both go LSB first.
- R6: With mode bit 0 set, the receiver takes the outgoing bit instead of `miso`, so the received byte equals the transmit byte whatever `miso` does.
- R7: Each SCK half-period is 2·(divisor+1) clocks. `irq` rises 32·(divisor+1)+1 clock edges after the edge that takes the start write.
- R8: Status bit 1 (busy) is 1 during a transfer. Status bit 0 (receive ready) and `irq` rise one cycle before busy returns to 0.
- R9: Reading address 1 clears receive-ready and `irq`. Reading any other address leaves them set.
- R10: A start write while busy is ignored. The running transfer keeps its timing and its data, even if the transmit register is rewritten at the same time.
- R11: While the port enable bit is 0, SCK stays at its idle level, `mosi` stays low and start writes are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 3 | Register byte address |
| busWrEn | input | 1 | Register write strobe, taken at the clock edge |
| busWrData | input | 8 | Register write data |
| busRdEn | input | 1 | Register read strobe; a read of address 1 has a side effect |
| busRdData | output | 8 | Register read data, combinational from `busAddr` |
| irq | output | 1 | Receive-ready interrupt, level |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench builds the block with its default 8-bit data and divisor widths. It sweeps divisor values 0 to 2 against all four combinations of idle level and sampling edge, both bit orders, loopback on and off, and three data patterns. This brings every edge-phase, bit-order and timing case within reach in a few tens of thousands of cycles. A behavioural slave inside the bench follows the configured edges, so both serial directions are checked against bytes the bench computes itself. Separate runs cover the disabled port and a start issued mid-transfer with a rewritten transmit byte.

// File: rtl/spi_byte_pkg.sv
package spi_byte_pkg;

  localparam int ADDR_MODE = 0;
  localparam int ADDR_RXD  = 1;
  localparam int ADDR_TXD  = 2;
  localparam int ADDR_CTRL = 3;
  localparam int ADDR_STAT = 4;
  localparam int ADDR_CDM  = 6;

  localparam int MB_LOOP = 0;
  localparam int MB_CI   = 1;
  localparam int MB_RD   = 2;
  localparam int MB_SPE  = 3;
  localparam int MB_SCP  = 4;
  localparam int MODE_BITS = 5;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_FINISH,
    ST_TAIL
  } xferState_t;

  typedef struct packed {
    logic load;
    logic sample;
    logic shift;
    logic toggle;
  } dpStrobe_t;

endpackage

// File: rtl/spi_byte_ctrl.sv
module spi_byte_ctrl
  import spi_byte_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busRdEn,
  output logic [DATA_W-1:0] busRdData,
  output logic              irq,
  input  logic [DATA_W-1:0] rxShiftIn,
  output logic [DATA_W-1:0] txByte,
  output dpStrobe_t         strobes,
  output logic              spe,
  output logic              ci,
  output logic              lsbFirst,
  output logic              loopEn,
  output logic              busy
);

  localparam int EDGES  = 2 * DATA_W;
  localparam int EDGE_W = $clog2(EDGES);

  xferState_t           state;
  logic [MODE_BITS-1:0] modeReg;
  logic [DATA_W-1:0]    txReg;
  logic [DATA_W-1:0]    rxReg;
  logic [DIV_W-1:0]     cdmReg;
  logic                 rbrFlag;
  logic [DIV_W:0]       divCnt;
  logic [EDGE_W-1:0]    edgeCnt;

  logic wrMode, wrTx, wrCdm, startReq, startGo, rdRx;
  logic edgeNow, leading, lastEdge, scp;
  logic [DIV_W:0] halfLimit;

  assign spe      = modeReg[MB_SPE];
  assign ci       = modeReg[MB_CI];
  assign lsbFirst = modeReg[MB_RD];
  assign loopEn   = modeReg[MB_LOOP];
  assign scp      = modeReg[MB_SCP];
  assign busy     = (state != ST_IDLE);
  assign irq      = rbrFlag;
  assign txByte   = txReg;

  assign wrMode   = busWrEn && (busAddr == ADDR_W'(ADDR_MODE));
  assign wrTx     = busWrEn && (busAddr == ADDR_W'(ADDR_TXD));
  assign wrCdm    = busWrEn && (busAddr == ADDR_W'(ADDR_CDM));
  assign startReq = busWrEn && (busAddr == ADDR_W'(ADDR_CTRL)) && busWrData[0];
  assign startGo  = startReq && spe && (state == ST_IDLE);
  assign rdRx     = busRdEn && (busAddr == ADDR_W'(ADDR_RXD));

  // half period of SCK is 2*(cdm+1) clocks: terminal count 2*cdm+1
  assign halfLimit = {cdmReg, 1'b1};
  assign edgeNow   = (state == ST_SHIFT) && (divCnt == halfLimit);
  assign leading   = ~edgeCnt[0];
  assign lastEdge  = (edgeCnt == EDGE_W'(EDGES - 1));

  always_comb begin
    strobes.load   = startGo;
    strobes.toggle = edgeNow;
    strobes.sample = edgeNow && (leading == scp);
    // phase-1 timing: first leading edge presents a bit already on the line
    strobes.shift  = edgeNow && (leading != scp) &&
                     !(!scp && (edgeCnt == '0));
  end

  always_comb begin
    busRdData = '0;
    case (busAddr)
      ADDR_W'(ADDR_MODE): busRdData = DATA_W'(modeReg);
      ADDR_W'(ADDR_RXD):  busRdData = rxReg;
      ADDR_W'(ADDR_TXD):  busRdData = txReg;
      ADDR_W'(ADDR_STAT): busRdData = DATA_W'({busy, rbrFlag});
      ADDR_W'(ADDR_CDM):  busRdData = DATA_W'(cdmReg);
      default:            busRdData = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      modeReg <= '0;
      txReg   <= '0;
      rxReg   <= '0;
      cdmReg  <= '0;
      rbrFlag <= 1'b0;
      divCnt  <= '0;
      edgeCnt <= '0;
    end else begin
      if (wrMode) modeReg <= busWrData[MODE_BITS-1:0];
      if (wrTx)   txReg   <= busWrData;
      if (wrCdm)  cdmReg  <= busWrData[DIV_W-1:0];

      case (state)
        ST_IDLE: begin
          if (startGo) begin
            state   <= ST_SHIFT;
            divCnt  <= '0;
            edgeCnt <= '0;
          end
        end
        ST_SHIFT: begin
          if (edgeNow) begin
            divCnt  <= '0;
            edgeCnt <= edgeCnt + 1'b1;
            if (lastEdge) state <= ST_FINISH;
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        ST_FINISH: begin
          rxReg <= rxShiftIn;
          state <= ST_TAIL;
        end
        default: state <= ST_IDLE;
      endcase

      if (state == ST_FINISH) rbrFlag <= 1'b1;
      else if (rdRx)          rbrFlag <= 1'b0;
    end
  end

  assert_rbr_before_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(rbrFlag));

  assert_ready_while_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rbrFlag) |-> busy);

  assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rdRx && state != ST_FINISH) |=> !irq);

  assert_restart_ignored_R10: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && state == ST_SHIFT && !edgeNow) |=>
      (edgeCnt == $past(edgeCnt) && divCnt == $past(divCnt) + 1'b1));

  assert_disabled_no_start_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !spe) |=> !busy);

endmodule

// File: rtl/spi_byte_datapath.sv
module spi_byte_datapath
  import spi_byte_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobes,
  input  logic [DATA_W-1:0] txByte,
  input  logic              lsbFirst,
  input  logic              loopEn,
  input  logic              ci,
  input  logic              spe,
  input  logic              busy,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic [DATA_W-1:0] rxShift
);

  logic [DATA_W-1:0] txShift;
  logic              sckLevel;
  logic              outBit;
  logic              inBit;

  assign outBit = lsbFirst ? txShift[0] : txShift[DATA_W-1];
  assign inBit  = loopEn ? outBit : miso;
  assign sck    = spe ? (sckLevel ^ ci) : ci;
  assign mosi   = spe && busy && outBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift  <= '0;
      rxShift  <= '0;
      sckLevel <= 1'b0;
    end else begin
      if (strobes.load) begin
        txShift  <= txByte;
        sckLevel <= 1'b0;
      end else begin
        if (strobes.toggle) sckLevel <= ~sckLevel;
        if (strobes.shift) begin
          if (lsbFirst) txShift <= {1'b0, txShift[DATA_W-1:1]};
          else          txShift <= {txShift[DATA_W-2:0], 1'b0};
        end
        if (strobes.sample) begin
          if (lsbFirst) rxShift <= {inBit, rxShift[DATA_W-1:1]};
          else          rxShift <= {rxShift[DATA_W-2:0], inBit};
        end
      end
    end
  end

  assert_sck_rests_R3: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sckLevel);

  assert_edges_only_busy_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.sample || strobes.shift || strobes.toggle) |-> busy);

  assert_one_action_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.sample && strobes.shift));

endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
  import spi_byte_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busRdEn,
  output logic [DATA_W-1:0] busRdData,
  output logic              irq,
  output logic              sck,
  output logic              mosi,
  input  logic              miso
);

  dpStrobe_t         strobes;
  logic [DATA_W-1:0] txByte;
  logic [DATA_W-1:0] rxShift;
  logic              spe, ci, lsbFirst, loopEn, busy;

  spi_byte_ctrl #(.DATA_W(DATA_W), .DIV_W(DIV_W), .ADDR_W(ADDR_W)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .busRdEn   (busRdEn),
    .busRdData (busRdData),
    .irq       (irq),
    .rxShiftIn (rxShift),
    .txByte    (txByte),
    .strobes   (strobes),
    .spe       (spe),
    .ci        (ci),
    .lsbFirst  (lsbFirst),
    .loopEn    (loopEn),
    .busy      (busy)
  );

  spi_byte_datapath #(.DATA_W(DATA_W)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .txByte   (txByte),
    .lsbFirst (lsbFirst),
    .loopEn   (loopEn),
    .ci       (ci),
    .spe      (spe),
    .busy     (busy),
    .miso     (miso),
    .sck      (sck),
    .mosi     (mosi),
    .rxShift  (rxShift)
  );

endmodule

// File: tb/test_spi_byte_master.sv
module test_spi_byte_master;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] busAddr = '0;
  logic       busWrEn = 1'b0;
  logic [7:0] busWrData = '0;
  logic       busRdEn = 1'b0;
  logic [7:0] busRdData;
  logic       irq, sck, mosi;
  logic       miso = 1'b0;

  int nVec = 0;
  int nBad = 0;
  logic [7:0] slvRx;

  always #10 clk = ~clk;

  spi_byte_master i_spi_byte_master (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData),
    .irq(irq), .sck(sck), .mosi(mosi), .miso(miso)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk);
    #1 busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    #1 d = busRdData;
    @(posedge clk);
    #1 busRdEn = 1'b0;
  endtask

  function automatic logic bitOf(input logic [7:0] b, input int k, input logic lsb);
    return lsb ? b[k] : b[7-k];
  endfunction

  task automatic runXfer(input int cdm, input logic scp, input logic ci,
                         input logic lsb, input logic loop,
                         input logic [7:0] txb, input logic [7:0] slvb,
                         input bit disturb);
    logic [7:0] d;
    int n;
    string tag;
    tag = loop ? "R6" : (lsb ? "R5" : "R4");
    busWrite(3'd6, 8'(cdm));
    busWrite(3'd0, {3'b000, scp, 1'b1, lsb, ci, loop});
    busWrite(3'd2, txb);
    busRead(3'd2, d);
    chk("R1 tx readback", d, txb);
    chk("R3 idle sck before", sck, ci);
    slvRx = '0;
    miso = scp ? bitOf(slvb, 0, lsb) : 1'b0;
    busWrite(3'd3, 8'h01);
    n = 0;
    fork
      begin
        do begin
          @(posedge clk); #1; n++;
        end while (!irq && n < 3000);
      end
      begin
        int sIdx;
        int rIdx;
        logic lead;
        sIdx = scp ? 1 : 0;
        rIdx = 0;
        for (int e = 0; e < 16; e++) begin
          @(sck);
          lead = (sck !== ci);
          if (lead == scp) begin
            if (lsb) slvRx[rIdx] = mosi;
            else     slvRx[7-rIdx] = mosi;
            rIdx++;
          end else begin
            miso = (sIdx < 8) ? bitOf(slvb, sIdx, lsb) : 1'b0;
            sIdx++;
          end
        end
      end
      begin
        if (disturb) begin
          repeat (20) @(posedge clk);
          busWrite(3'd2, ~txb);
          busWrite(3'd3, 8'h01);
        end
      end
    join
    chk("R7 cycles start to irq", n, 32 * (cdm + 1) + 1);
    busRead(3'd4, d);
    chk("R8 status ready while busy", d, 8'h03);
    busRead(3'd4, d);
    chk("R8 busy cleared next cycle", d, 8'h01);
    chk("R9 irq held after status read", irq, 1'b1);
    busRead(3'd1, d);
    chk({tag, " received byte"}, d, loop ? txb : slvb);
    chk(disturb ? "R10 slave byte kept" : "R2 slave got tx byte", slvRx, txb);
    chk("R9 irq cleared by rx read", irq, 1'b0);
    busRead(3'd4, d);
    chk("R9 status after read", d, 8'h00);
    chk("R3 idle sck after", sck, ci);
    chk("R11 mosi idle low", mosi, 1'b0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset values
    for (int a = 0; a < 8; a++) begin
      busRead(3'(a), d);
      chk("R1 reset register", d, 8'h00);
    end
    chk("R1 reset irq", irq, 1'b0);
    chk("R1 reset sck", sck, 1'b0);
    chk("R1 reset mosi", mosi, 1'b0);
    // R1 readback and ignored writes
    busWrite(3'd0, 8'hFF);
    busRead(3'd0, d);
    chk("R1 mode upper bits read 0", d, 8'h1F);
    busWrite(3'd0, 8'h00);
    busWrite(3'd6, 8'hA5);
    busRead(3'd6, d);
    chk("R1 divisor readback", d, 8'hA5);
    busWrite(3'd4, 8'hFF);
    busWrite(3'd1, 8'hFF);
    busWrite(3'd5, 8'hFF);
    busRead(3'd4, d);
    chk("R1 status write ignored", d, 8'h00);
    busRead(3'd1, d);
    chk("R1 rx write ignored", d, 8'h00);
    busRead(3'd5, d);
    chk("R1 reserved reads 0", d, 8'h00);

    // R11 disabled port: idle high, start ignored
    busWrite(3'd6, 8'h00);
    busWrite(3'd2, 8'hFF);
    busWrite(3'd0, 8'h12);
    busWrite(3'd3, 8'h01);
    for (int k = 0; k < 100; k++) begin
      @(posedge clk); #1;
      if (sck !== 1'b1 || mosi !== 1'b0 || irq !== 1'b0) begin
        chk("R11 disabled outputs", {sck, mosi, irq}, 3'b100);
        break;
      end
    end
    chk("R11 disabled sck idle", sck, 1'b1);
    busRead(3'd4, d);
    chk("R11 start ignored", d, 8'h00);

    // sweep of all modes
    for (int cdm = 0; cdm < 3; cdm++)
      for (int m = 0; m < 16; m++)
        for (int p = 0; p < 3; p++) begin
          logic [7:0] txb;
          logic [7:0] slvb;
          txb  = 8'((p * 97 + m * 13 + cdm * 5 + 1) & 255);
          slvb = 8'((p * 53 + m * 29 + 200) & 255);
          if (p == 2) begin txb = 8'h80; slvb = 8'h01; end
          runXfer(cdm, m[0], m[1], m[2], m[3], txb, slvb, 1'b0);
        end

    // R10 start while busy, transmit byte rewritten mid-transfer
    runXfer(3, 1'b1, 1'b0, 1'b0, 1'b1, 8'h3C, 8'hF0, 1'b1);
    runXfer(3, 1'b0, 1'b1, 1'b1, 1'b0, 8'h5A, 8'h96, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule